// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit

This block is a multi-cycle arithmetic engine that sits beside an integer datapath. It takes two 32-bit operands and one of four commands: signed or unsigned multiply, and signed or unsigned divide. The result goes into a pair of result registers, exposed as `hi` and `lo`. A multiply fills the pair with its double-width product. A divide places the remainder in `hi` and the quotient in `lo`.

Multiplication uses shift-and-add and retires one multiplier bit per cycle. Division uses restoring long division and produces one quotient bit per cycle. Signed commands work on magnitudes, and the signs are corrected in one extra cycle at the end. The unit never reports overflow or a zero divisor. Software makes those checks if it needs them.

Commands enter through a valid/ready handshake:
- A command is taken on a rising clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` stays low while a command is in flight. Any `in_valid` seen in that time is ignored, so the producer must hold its command until ready returns.
- Results have no back-pressure. `done` pulses once, and the `hi`/`lo` registers keep the values until the next completion.

Top module: `muldiv_unit`

## Requirements
- R1: Op code 2'b00 is a signed multiply and 2'b01 an unsigned multiply. On completion, `hi` holds bits 63..32 and `lo` bits 31..0 of the 64-bit product.
- R2: Op code 2'b11 is an unsigned divide. On completion, `lo` holds the quotient and `hi` the remainder.
- R3: Op code 2'b10 is a signed divide. The quotient is truncated toward zero and the remainder takes the sign of the dividend. For 0x80000000 divided by 0xFFFFFFFF the result is `lo` = 0x80000000 and `hi` = 0.
- R4: A divide by zero, signed or unsigned, completes with the normal latency and signals no error. It gives `lo` = 0xFFFFFFFF and `hi` equal to the dividend.
- R5: After a command is accepted, `in_ready` is low for exactly 33 cycles and then returns high.
- R6: `done` is high for exactly one cycle. That cycle is the first one in which `in_ready` is high again and the new `hi`/`lo` values are visible.
- R7: `hi` and `lo` change only in a cycle where `done` is high. An `in_valid` presented while `in_ready` is low has no effect.
- R8: After reset, `in_ready` is 1, `done` is 0, and `hi` and `lo` are 0.
- R9: A new command can be accepted in the same cycle that `done` is high, with no idle cycle between commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command present |
| in_ready | output | 1 | Unit idle; command accepted when both high |
| in_op | input | 2 | Command: 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| in_a | input | 32 | Multiplicand or dividend |
| in_b | input | 32 | Multiplier or divisor |
| done | output | 1 | One-cycle completion pulse |
| hi | output | 32 | Upper product half or remainder |
| lo | output | 32 | Lower product half or quotient |

## Verification
The bench targets the sign corner cases where a design can go wrong:
- Negative-by-negative products and the most-negative operand. A missing fix-up here gives the wrong `hi` half.
- Signed quotients with mixed signs. These expose a remainder that takes the sign of the quotient instead of the dividend.
- The single signed divide that overflows.
- Zero divisors, signed and unsigned. A sign fix-up applied to the all-ones quotient turns it into 1.

Two other faults are also targeted:
- An off-by-one iteration count shows up as a shifted product or quotient and a wrong `done` cycle.
- Commands offered while the unit is busy must leave both `hi`/`lo` and the timing untouched. The bench checks that together with back-to-back issue in the `done` cycle.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MULS = 2'b00,
    OP_MULU = 2'b01,
    OP_DIVS = 2'b10,
    OP_DIVU = 2'b11
  } md_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FIX  = 2'b10
  } md_state_e;
endpackage

// File: rtl/muldiv_prep.sv
// Turns operands into magnitudes and records which results need negation.
module muldiv_prep
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  md_op_e         op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   mag_a,
  output logic [W-1:0]   mag_b,
  output logic           is_div,
  output logic           neg_prod,
  output logic           neg_quo,
  output logic           neg_rem
);
  logic signed_op, sa, sb, b_zero;

  always_comb begin
    signed_op = (op == OP_MULS) || (op == OP_DIVS);
    is_div    = (op == OP_DIVS) || (op == OP_DIVU);
    sa        = signed_op & a[W-1];
    sb        = signed_op & b[W-1];
    b_zero    = (b == '0);
    mag_a     = sa ? (~a + 1'b1) : a;
    mag_b     = sb ? (~b + 1'b1) : b;
    neg_prod  = sa ^ sb;
    // a zero divisor keeps the all-ones quotient unchanged
    neg_quo   = (sa ^ sb) & ~b_zero;
    neg_rem   = sa;
  end
endmodule

// File: rtl/muldiv_iter.sv
// One bit per step: shift-and-add multiply or restoring divide on magnitudes.
module muldiv_iter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         is_div,
  input  logic [W-1:0] mag_a,
  input  logic [W-1:0] mag_b,
  output logic [W-1:0] raw_hi,
  output logic [W-1:0] raw_lo
);
  logic [W-1:0] acc_q, lsh_q, opb_q;
  logic [W-1:0] acc_d, lsh_d;
  logic [W:0]   add_sum;
  logic [W:0]   rem_sh;
  logic [W+1:0] trial;
  logic         borrow;

  always_comb begin
    add_sum = {1'b0, acc_q} + (lsh_q[0] ? {1'b0, opb_q} : '0);
    rem_sh  = {acc_q, lsh_q[W-1]};
    trial   = {1'b0, rem_sh} - {2'b00, opb_q};
    borrow  = trial[W+1];
    if (is_div) begin
      // negative trial: restore the shifted remainder, quotient bit 0
      acc_d = borrow ? rem_sh[W-1:0] : trial[W-1:0];
      lsh_d = {lsh_q[W-2:0], ~borrow};
    end else begin
      acc_d = add_sum[W:1];
      lsh_d = {add_sum[0], lsh_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      lsh_q <= '0;
      opb_q <= '0;
    end else if (load) begin
      acc_q <= '0;
      lsh_q <= mag_a;
      opb_q <= mag_b;
    end else if (step) begin
      acc_q <= acc_d;
      lsh_q <= lsh_d;
    end
  end

  assign raw_hi = acc_q;
  assign raw_lo = lsh_q;
endmodule

// File: rtl/muldiv_fix.sv
// Final sign correction applied to the magnitude results.
module muldiv_fix #(
  parameter int W = 32
) (
  input  logic         is_div,
  input  logic         neg_prod,
  input  logic         neg_quo,
  input  logic         neg_rem,
  input  logic [W-1:0] raw_hi,
  input  logic [W-1:0] raw_lo,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo
);
  localparam int PW = 2 * W;
  logic [PW-1:0] prod, prod_s;

  always_comb begin
    prod   = {raw_hi, raw_lo};
    prod_s = neg_prod ? (~prod + 1'b1) : prod;
    if (is_div) begin
      res_hi = neg_rem ? (~raw_hi + 1'b1) : raw_hi;
      res_lo = neg_quo ? (~raw_lo + 1'b1) : raw_lo;
    end else begin
      res_hi = prod_s[PW-1:W];
      res_lo = prod_s[W-1:0];
    end
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [1:0]   in_op,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         done,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  md_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic         accept, step;
  logic [W-1:0] mag_a, mag_b, raw_hi, raw_lo, res_hi, res_lo;
  logic         p_div, p_nprod, p_nquo, p_nrem;
  logic         div_q, nprod_q, nquo_q, nrem_q;

  assign in_ready = (state_q == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign step     = (state_q == ST_RUN);

  muldiv_prep #(.W(W)) u_prep (
    .op(md_op_e'(in_op)), .a(in_a), .b(in_b),
    .mag_a(mag_a), .mag_b(mag_b), .is_div(p_div),
    .neg_prod(p_nprod), .neg_quo(p_nquo), .neg_rem(p_nrem)
  );

  muldiv_iter #(.W(W)) u_iter (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(step), .is_div(div_q),
    .mag_a(mag_a), .mag_b(mag_b), .raw_hi(raw_hi), .raw_lo(raw_lo)
  );

  muldiv_fix #(.W(W)) u_fix (
    .is_div(div_q), .neg_prod(nprod_q), .neg_quo(nquo_q), .neg_rem(nrem_q),
    .raw_hi(raw_hi), .raw_lo(raw_lo), .res_hi(res_hi), .res_lo(res_lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      div_q   <= 1'b0;
      nprod_q <= 1'b0;
      nquo_q  <= 1'b0;
      nrem_q  <= 1'b0;
      done    <= 1'b0;
      hi      <= '0;
      lo      <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
          div_q   <= p_div;
          nprod_q <= p_nprod;
          nquo_q  <= p_nquo;
          nrem_q  <= p_nrem;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= ST_FIX;
        end
        ST_FIX: begin
          state_q <= ST_IDLE;
          hi      <= res_hi;
          lo      <= res_lo;
          done    <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [1:0]   in_op,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic         done,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo
);
  logic [15:0] lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_cnt <= '0;
    else if (!in_ready) lat_cnt <= lat_cnt + 1'b1;
    else lat_cnt <= '0;
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);                          // R5
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_cnt == 16'(W + 1)));                              // R5
  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);                                             // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(hi) && $stable(lo)));                        // R7
endmodule

bind muldiv_unit muldiv_unit_chk #(.W(W)) u_chk (.*);

// File: tb/tb_muldiv_unit.sv
`timescale 1ns/1ps
module tb_muldiv_unit;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [1:0]   in_op = 2'b00;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic         done;
  logic [W-1:0] hi, lo;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  muldiv_unit #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .done(done), .hi(hi), .lo(lo)
  );

  // Reference model: behavioural timing and arithmetic
  bit          m_busy = 1'b0;
  bit          m_done = 1'b0;
  int          m_cnt  = 0;
  int          m_ops  = 0;
  logic [31:0] m_hi = '0, m_lo = '0, p_hi = '0, p_lo = '0;
  string       m_tag = "R8", p_tag = "R1";

  task automatic ref_res(input logic [1:0] op, input logic [31:0] a, b,
                         output logic [31:0] rh, output logic [31:0] rl,
                         output string tag);
    longint          sp, sa, sb, q, r;
    longint unsigned up;
    case (op)
      2'b00: begin
        sp = longint'($signed(a)) * longint'($signed(b));
        rh = sp[63:32]; rl = sp[31:0]; tag = "R1";
      end
      2'b01: begin
        up = {32'h0, a} * {32'h0, b};
        rh = up[63:32]; rl = up[31:0]; tag = "R1";
      end
      2'b11: begin
        if (b == 0) begin rl = 32'hFFFF_FFFF; rh = a; tag = "R4"; end
        else begin rl = a / b; rh = a % b; tag = "R2"; end
      end
      default: begin
        if (b == 0) begin rl = 32'hFFFF_FFFF; rh = a; tag = "R4"; end
        else begin
          sa = longint'($signed(a)); sb = longint'($signed(b));
          q = sa / sb; r = sa % sb;
          rl = q[31:0]; rh = r[31:0]; tag = "R3";
        end
      end
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 1'b0; m_done = 1'b0; m_cnt = 0;
      m_hi = '0; m_lo = '0;
    end else begin
      m_done = 1'b0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == W + 1) begin
          m_busy = 1'b0; m_done = 1'b1;
          m_hi = p_hi; m_lo = p_lo; m_tag = p_tag;
        end
      end else if (in_valid) begin
        ref_res(in_op, in_a, in_b, p_hi, p_lo, p_tag);
        m_busy = 1'b1; m_cnt = 0; m_ops++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Compare on every falling edge, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      string th;
      th = m_done ? m_tag : ((m_ops == 0) ? "R8" : "R7");
      chk(in_ready == !m_busy, m_done ? "R9" : "R5", "in_ready",
          32'(in_ready), 32'(!m_busy));
      chk(done == m_done, "R6", "done", 32'(done), 32'(m_done));
      chk(hi == m_hi, th, "hi", hi, m_hi);
      chk(lo == m_lo, th, "lo", lo, m_lo);
    end
  end

  task automatic issue(input logic [1:0] op, input logic [31:0] a, b, input int noise);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    // R7: commands offered while busy must be ignored
    for (int k = 0; k < noise; k++) begin
      in_valid = 1'b1; in_op = 2'(k); in_a = 32'h1234_5678 + k; in_b = 32'h0;
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = 32'h1ACE_B00C;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;                       // R8 checked from here on
    repeat (2) @(negedge clk);
    issue(2'b00, 32'd7, 32'hFFFF_FFFA, 0);         // R1 signed
    issue(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4); // R1 unsigned, R7 noise
    issue(2'b00, 32'h8000_0000, 32'h8000_0000, 0); // R1
    issue(2'b00, 32'hFFFF_FFFF, 32'h0000_0001, 0); // R1
    issue(2'b11, 32'd100, 32'd7, 0);               // R2
    issue(2'b11, 32'hFFFF_FFFF, 32'd1, 0);         // R2
    issue(2'b10, 32'hFFFF_FFF9, 32'd2, 3);         // R3
    issue(2'b10, 32'd7, 32'hFFFF_FFFE, 0);         // R3
    issue(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 0); // R3 overflow case
    issue(2'b11, 32'd5, 32'd0, 0);                 // R4 unsigned
    issue(2'b10, 32'hFFFF_FFF7, 32'd0, 0);         // R4 signed negative dividend
    issue(2'b10, 32'd9, 32'd0, 0);                 // R4 signed positive dividend
    for (int i = 0; i < 24; i++) begin             // R9 back-to-back issue
      logic [31:0] ra, rb;
      seed = seed * 32'd1664525 + 32'd1013904223; ra = seed;
      seed = seed * 32'd1664525 + 32'd1013904223; rb = seed >> (i % 28);
      issue(2'(i), ra, rb, 0);
    end
    repeat (40) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule